// File: doc/BRIEF.md
# SPI Master Chip-Select Decoder

This block drives the four active-low chip-select lines of an SPI master. It also reports which of the four chip-select configuration slots governs the current transfer. Each transfer start supplies a 4-bit select code. In fixed-select mode the code comes from a mode-register field. In variable-select mode it comes from the code that arrives with the transmit word.

A decode enable picks how the code reaches the lines. With decoding off, the lines are driven one-hot: the line at the lowest-numbered zero bit of the code goes low, and the other lines stay high. With decoding on, the code is placed on the lines unchanged, so that an external demultiplexer can address up to fifteen peripherals. In that case each configuration slot serves a group of four consecutive codes.

Between transfers all lines rest high. A transfer may optionally keep its line asserted after it ends. The block also produces a mode-fault flag from line 0, which is observed as an input. The flag is suppressed whenever lines are kept asserted after a transfer.

Top module: `spi_cs_decoder`

## Requirements
- R1: After reset, `cs_n` is 4'hF, `cfg_idx` is 0 and `mode_fault` is 0.
- R2: With `decode_en`=0, an accepted start drives low only the line whose index is the lowest zero bit of the code. Every other line stays high, so at most one line is low.
- R3: With `decode_en`=1, an accepted start drives the 4-bit code unchanged onto `cs_n[3:0]`, with code bit i on line i.
- R4: The code is `mode_code` when `variable_sel`=0 and `word_code` when `variable_sel`=1.
- R5: A start whose code is 4'hF is not accepted. It leaves `cs_n` and `cfg_idx` unchanged.
- R6: On an accepted start, `cfg_idx` becomes code[3:2] when decoding is on, and the index of the lowest zero bit when decoding is off.
- R7: `xfer_end` with `csaat`=0 returns `cs_n` to 4'hF on the next cycle. With `csaat`=1, the lines keep their value.
- R8: `cs_n` changes only in the cycle after an accepted start or after `xfer_end`. An accepted start takes priority over `xfer_end` in the same cycle.
- R9: `mode_fault` is 1 in the cycle after a cycle in which all of the following hold: `cs_in0`=0, `master_en`=1, `mfault_dis`=0 and `csaat`=0. Otherwise it is 0, and it is always 0 after a cycle with `csaat`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master operation enabled |
| decode_en | input | 1 | 1: raw code for an external decoder, 0: one-hot drive |
| variable_sel | input | 1 | 1: code from transmit word, 0: code from mode register |
| mode_code | input | 4 | Fixed-select code |
| word_code | input | 4 | Per-word select code |
| xfer_start | input | 1 | Transfer start pulse |
| xfer_end | input | 1 | Transfer end pulse |
| csaat | input | 1 | Keep chip select asserted after transfer end |
| mfault_dis | input | 1 | Software disable of mode-fault detection |
| cs_in0 | input | 1 | Sampled external level of line 0 |
| cs_n | output | 4 | Active-low chip-select lines |
| cfg_idx | output | 2 | Configuration slot for the current transfer |
| mode_fault | output | 1 | Mode fault detected on line 0 |

## Verification
One-hot mode is tried with codes that have a single zero and with codes that have several zeros, including 4'h0. This separates a lowest-zero priority from a highest-zero priority and from raw pass-through. Decoded mode uses codes from all four groups, 4'h1, 4'h6, 4'hB and 4'hE, which shows that `cfg_idx` follows the upper code bits and not the zero position. Unequal `mode_code` and `word_code` values reveal a swapped source. Start-with-end collisions, 4'hF starts and toggling `csaat` separate the release, priority and mode-fault gating rules.

// File: rtl/spi_cs_decoder.sv
module spi_cs_decoder #(
  parameter int CS_W = 4,
  localparam int IDX_W = $clog2(CS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_en,
  input  logic             decode_en,
  input  logic             variable_sel,
  input  logic [CS_W-1:0]  mode_code,
  input  logic [CS_W-1:0]  word_code,
  input  logic             xfer_start,
  input  logic             xfer_end,
  input  logic             csaat,
  input  logic             mfault_dis,
  input  logic             cs_in0,
  output logic [CS_W-1:0]  cs_n,
  output logic [IDX_W-1:0] cfg_idx,
  output logic             mode_fault
);

  logic [CS_W-1:0]  code;
  logic [CS_W-1:0]  onehot_n;
  logic [IDX_W-1:0] low_idx;
  logic             accept;

  assign code   = variable_sel ? word_code : mode_code;
  assign accept = xfer_start && (code != '1);

  always_comb begin
    onehot_n = '1;
    low_idx  = '0;
    for (int i = CS_W - 1; i >= 0; i--) begin
      if (!code[i]) begin
        onehot_n    = '1;
        onehot_n[i] = 1'b0;
        low_idx     = i[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n       <= '1;
      cfg_idx    <= '0;
      mode_fault <= 1'b0;
    end else begin
      if (accept) begin
        cs_n    <= decode_en ? code : onehot_n;
        cfg_idx <= decode_en ? code[CS_W-1 -: IDX_W] : low_idx;
      end else if (xfer_end && !csaat) begin
        cs_n <= '1;
      end
      mode_fault <= master_en && !mfault_dis && !csaat && !cs_in0;
    end
  end

endmodule

module spi_cs_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       decode_en,
  input logic       variable_sel,
  input logic [3:0] mode_code,
  input logic [3:0] word_code,
  input logic       xfer_start,
  input logic       xfer_end,
  input logic       csaat,
  input logic [3:0] cs_n,
  input logic       mode_fault
);
  logic [3:0] sel;
  assign sel = variable_sel ? word_code : mode_code;

  assert_onehot_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !decode_en && sel != 4'hF) |=> $onehot0(~cs_n));

  assert_raw_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && decode_en && sel != 4'hF) |=> cs_n == $past(sel));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end && !csaat && !xfer_start) |=> cs_n == 4'hF);

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_start && !xfer_end) |=> $stable(cs_n));

  assert_fault_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csaat |=> !mode_fault);
endmodule

bind spi_cs_decoder spi_cs_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .decode_en(decode_en), .variable_sel(variable_sel),
  .mode_code(mode_code), .word_code(word_code), .xfer_start(xfer_start),
  .xfer_end(xfer_end), .csaat(csaat), .cs_n(cs_n), .mode_fault(mode_fault)
);

// File: tb/spi_cs_decoder_test.sv
module spi_cs_decoder_test;
  logic clk = 0, rst_n = 0;
  logic master_en = 0, decode_en = 0, variable_sel = 0;
  logic [3:0] mode_code = 4'hF, word_code = 4'hF;
  logic xfer_start = 0, xfer_end = 0, csaat = 0, mfault_dis = 0, cs_in0 = 1;
  logic [3:0] cs_n;
  logic [1:0] cfg_idx;
  logic mode_fault;

  typedef struct { logic [3:0] cs; logic [1:0] idx; logic mf; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  logic [3:0] m_cs = 4'hF;
  logic [1:0] m_idx = 2'd0;

  always #4 clk = ~clk;

  spi_cs_decoder uut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .decode_en(decode_en),
    .variable_sel(variable_sel), .mode_code(mode_code), .word_code(word_code),
    .xfer_start(xfer_start), .xfer_end(xfer_end), .csaat(csaat),
    .mfault_dis(mfault_dis), .cs_in0(cs_in0), .cs_n(cs_n), .cfg_idx(cfg_idx),
    .mode_fault(mode_fault)
  );

  task automatic step(input logic dec, input logic vs, input logic [3:0] mc,
                      input logic [3:0] wc, input logic st, input logic en,
                      input logic hold, input logic me, input logic dis,
                      input logic l0, input string tag);
    logic [3:0] c;
    exp_t e;
    @(negedge clk);
    decode_en = dec; variable_sel = vs; mode_code = mc; word_code = wc;
    xfer_start = st; xfer_end = en; csaat = hold; master_en = me;
    mfault_dis = dis; cs_in0 = l0;
    c = vs ? wc : mc;
    if (st && c != 4'hF) begin
      if (dec) begin
        m_cs = c; m_idx = c[3:2];
      end else begin
        for (int i = 0; i < 4; i++)
          if (!c[i]) begin m_cs = ~(4'b1 << i); m_idx = 2'(i); break; end
      end
    end else if (en && !hold) m_cs = 4'hF;
    e.cs = m_cs; e.idx = m_idx; e.mf = me && !dis && !hold && !l0; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cs_n !== e.cs || cfg_idx !== e.idx || mode_fault !== e.mf) begin
        fails++;
        $display("FAIL %s: cs_n=%h idx=%0d mf=%b expected cs_n=%h idx=%0d mf=%b",
                 e.tag, cs_n, cfg_idx, mode_fault, e.cs, e.idx, e.mf);
      end
    end
  end

  initial begin
    #3000;
    fails++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    #20;
    checks++;
    if (cs_n !== 4'hF || cfg_idx !== 2'd0 || mode_fault !== 1'b0) begin
      fails++;
      $display("FAIL R1: cs_n=%h idx=%0d mf=%b expected F 0 0", cs_n, cfg_idx, mode_fault);
    end
    @(negedge clk); rst_n = 1;
    //       dec vs mc    wc    st en hold me dis l0
    step(0, 0, 4'hB, 4'hF, 1, 0, 0, 0, 0, 1, "R2 single zero");
    step(0, 0, 4'hB, 4'hF, 0, 1, 0, 0, 0, 1, "R7 release");
    step(0, 0, 4'h6, 4'hF, 1, 0, 0, 0, 0, 1, "R2 lowest zero R6");
    step(0, 0, 4'h0, 4'hF, 1, 0, 0, 0, 0, 1, "R2 all zero");
    step(0, 1, 4'hE, 4'h7, 1, 0, 0, 0, 0, 1, "R4 variable source");
    step(0, 1, 4'hE, 4'h7, 0, 0, 0, 0, 0, 1, "R8 quiet");
    step(0, 0, 4'hF, 4'h0, 1, 0, 0, 0, 0, 1, "R5 code F ignored");
    step(1, 0, 4'h1, 4'hF, 1, 0, 0, 0, 0, 1, "R3 decoded 1 R6");
    step(1, 0, 4'h6, 4'hF, 1, 0, 0, 0, 0, 1, "R3 decoded 6 R6");
    step(1, 1, 4'h2, 4'hB, 1, 0, 0, 0, 0, 1, "R4 R3 decoded B");
    step(1, 0, 4'hE, 4'hF, 1, 0, 0, 0, 0, 1, "R3 decoded E R6");
    step(1, 0, 4'hE, 4'hF, 0, 1, 1, 0, 0, 1, "R7 hold after end");
    step(1, 0, 4'hF, 4'hF, 1, 0, 1, 0, 0, 1, "R5 code F keeps held");
    step(1, 0, 4'h3, 4'hF, 1, 1, 0, 0, 0, 1, "R8 start beats end");
    step(1, 0, 4'h3, 4'hF, 0, 1, 0, 0, 0, 1, "R7 release decoded");
    step(0, 0, 4'hD, 4'hF, 0, 0, 0, 1, 0, 0, "R9 fault");
    step(0, 0, 4'hD, 4'hF, 0, 0, 1, 1, 0, 0, "R9 csaat gates");
    step(0, 0, 4'hD, 4'hF, 0, 0, 0, 1, 1, 0, "R9 disabled");
    step(0, 0, 4'hD, 4'hF, 0, 0, 0, 0, 0, 0, "R9 master off");
    step(0, 0, 4'hD, 4'hF, 0, 0, 0, 1, 0, 1, "R9 line high");
    step(0, 0, 4'hD, 4'hF, 1, 0, 0, 1, 0, 1, "R2 code D R6");
    step(0, 0, 4'hD, 4'hF, 0, 0, 0, 0, 0, 1, "R8 idle");
    @(negedge clk); @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule